// File: doc/BRIEF.md
# Register Bit Flag and Compare-Branch Execute Unit

This unit sits in the execute stage of a small five-stage integer core that has no floating-point hardware. Software running a network stack keeps many one-bit flags, so the unit lets any 32-bit general register act as a word of addressable flags. It can force one chosen bit of a source register high or low and write the result back. It can also decide a branch from one chosen bit, or from a signed comparison of two registers.

Each cycle the unit takes one decoded operation. With it come two register operands, a bit index, a destination register number, the current PC and a 16-bit word offset. One clock edge later it presents a registered result to the memory stage: a write-back value, a destination and a write enable, or a taken flag and a target address. Fetch, hazard detection and forwarding are handled elsewhere in the core.

Operation codes on `op_code` (3 bits): 0 = no operation, 1 = set bit, 2 = clear bit, 3 = branch if bit set, 4 = branch if bit clear, 5 = branch if less, 6 = branch if greater, 7 = unused.

Top module: `bitbr_unit`

## Requirements
- R1: While `rst_n` is low, and after the first clock edge seen in reset, `wb_en`, `wb_data`, `wb_reg`, `br_taken` and `br_target` are all zero.
- R2: Take a valid set-bit op (code 1) with a nonzero destination. One cycle later `wb_en` is 1, `wb_reg` equals the destination, and `wb_data` equals `rs_val` with bit `bit_idx` forced to 1 and every other bit copied.
- R3: Take a valid clear-bit op (code 2) with a nonzero destination. One cycle later `wb_en` is 1, `wb_reg` equals the destination, and `wb_data` equals `rs_val` with bit `bit_idx` forced to 0 and every other bit copied.
- R4: A valid branch-if-bit-set op (code 3) gives `br_taken` = 1 one cycle later exactly when bit `bit_idx` of `rs_val` is 1.
- R5: A valid branch-if-bit-clear op (code 4) gives `br_taken` = 1 one cycle later exactly when bit `bit_idx` of `rs_val` is 0.
- R6: A valid branch-if-less op (code 5) is taken exactly when `rs_val` < `rt_val` as signed two's-complement values.
- R7: A valid branch-if-greater op (code 6) is taken exactly when `rs_val` > `rt_val` as signed values. Equal operands take neither code 5 nor code 6.
- R8: For any valid branch op (codes 3 to 6), `br_target` one cycle later equals `pc + 4` plus the sign-extended `br_offset` multiplied by 4, modulo 2^32, whether or not the branch is taken. For every other cycle it is zero.
- R9: Branch ops never raise `wb_en`, and set-bit and clear-bit ops never raise `br_taken`.
- R10: A set-bit or clear-bit op whose destination is register 0 leaves `wb_en` low, and `wb_data` and `wb_reg` read zero. `wb_en` is never high with `wb_reg` = 0.
- R11: With `op_valid` low, or with code 0 or 7, the next cycle shows `wb_en` = 0, `br_taken` = 0 and all data outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Decoded operation code |
| rs_val | input | 32 | First register operand (flag word, compare left side) |
| rt_val | input | 32 | Second register operand (compare right side) |
| bit_idx | input | 5 | Selected bit number |
| dest_reg | input | 5 | Write-back register number |
| pc | input | 32 | Address of the current instruction |
| br_offset | input | 16 | Signed branch offset in words |
| wb_en | output | 1 | Register write enable |
| wb_reg | output | 5 | Register number to write |
| wb_data | output | 32 | Value to write |
| br_taken | output | 1 | Branch is taken |
| br_target | output | 32 | Branch destination address |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 5-bit index, a 32-bit PC and a 16-bit offset. With these values bit 31 can be selected, so set and clear of the sign bit are reachable, and signed compares can cross the most negative and most positive values, where an unsigned or overflowing compare would go wrong. The 16-bit offset allows backward branches whose targets wrap below address zero. Directed cases cover these corners, and a long stretch of random operations, including register 0 and unused codes, is compared every cycle with a behavioural model.

// File: rtl/bitbr_pkg.sv
// Package bitbr_pkg
// Shared operation encoding for the bit-flag and compare-branch unit.
// Assumes a 3-bit operation field decoded earlier in the pipeline.
package bitbr_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        BB_NOP   = 3'd0,
        BB_SET   = 3'd1,
        BB_CLR   = 3'd2,
        BB_BRSET = 3'd3,
        BB_BRCLR = 3'd4,
        BB_BRLT  = 3'd5,
        BB_BRGT  = 3'd6,
        BB_RSVD  = 3'd7
    } bb_op_e;

    // True for the four branch operations
    function automatic logic is_branch(input bb_op_e op);
        return (op == BB_BRSET) || (op == BB_BRCLR) ||
               (op == BB_BRLT)  || (op == BB_BRGT);
    endfunction

    // True for the two register-writing bit operations
    function automatic logic is_bitwrite(input bb_op_e op);
        return (op == BB_SET) || (op == BB_CLR);
    endfunction

endpackage

// File: rtl/bitbr_mask_dec.sv
// Module bitbr_mask_dec
// Turns a binary bit number into a one-hot mask over the data word.
// Assumes DATA_W <= 2**IDX_W, so every index names a bit or no bit.
module bitbr_mask_dec #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);

    // One comparator per bit position
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign mask[gi] = (idx == IDX_W'(gi));
    end

endmodule

// File: rtl/bitbr_field_op.sv
// Module bitbr_field_op
// Applies a one-hot mask to a source word. It produces the set and
// cleared versions of the word and the value of the selected bit.
// Assumes the mask has exactly one bit high.
module bitbr_field_op #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] set_val,
    output logic [DATA_W-1:0] clr_val,
    output logic              sel_bit
);

    // Merge the mask into the word and pick out the selected bit
    always_comb begin
        set_val = src | mask;
        clr_val = src & ~mask;
        sel_bit = |(src & mask);
    end

endmodule

// File: rtl/bitbr_cmp.sv
// Module bitbr_cmp
// Signed two's-complement magnitude compare of two words.
// Uses one widened subtract, so it cannot overflow at the extremes.
module bitbr_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              lt,
    output logic              gt
);

    logic [DATA_W:0] diff;
    logic            eq;

    // Sign-extend by one bit, subtract, and read the sign of the result
    always_comb begin
        diff = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        eq   = (a == b);
        lt   = diff[DATA_W];
        gt   = !diff[DATA_W] && !eq;
    end

endmodule

// File: rtl/bitbr_target.sv
// Module bitbr_target
// Branch destination: address of the next instruction plus a signed
// offset counted in instructions. Assumes ADDR_W > OFF_W and fixed-size
// instructions of INSN_BYTES bytes, a power of two.
module bitbr_target #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);

    localparam int SH = $clog2(INSN_BYTES);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] next_pc;

    // Sign-extend, scale to bytes and add to the next sequential PC
    always_comb begin
        off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        next_pc = pc + ADDR_W'(INSN_BYTES);
        target  = next_pc + (off_ext << SH);
    end

endmodule

// File: rtl/bitbr_unit.sv
// Module bitbr_unit (top)
// Execute-stage unit. It does set-bit and clear-bit writes on a register
// and resolves branches on a bit, on signed less-than and on signed
// greater-than. Results are registered once, at the boundary to the next
// stage. Assumes decoded ops and already forwarded operands at its inputs.
// Register 0 is hard-wired to zero, so writes to it are dropped.
module bitbr_unit #(
    parameter int DATA_W     = 32,
    parameter int IDX_W      = $clog2(DATA_W),
    parameter int REG_AW     = 5,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [bitbr_pkg::OP_W-1:0]    op_code,
    input  logic [DATA_W-1:0]             rs_val,
    input  logic [DATA_W-1:0]             rt_val,
    input  logic [IDX_W-1:0]              bit_idx,
    input  logic [REG_AW-1:0]             dest_reg,
    input  logic [ADDR_W-1:0]             pc,
    input  logic [OFF_W-1:0]              br_offset,
    output logic                          wb_en,
    output logic [REG_AW-1:0]             wb_reg,
    output logic [DATA_W-1:0]             wb_data,
    output logic                          br_taken,
    output logic [ADDR_W-1:0]             br_target
);

    import bitbr_pkg::*;

    bb_op_e            op;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] set_val;
    logic [DATA_W-1:0] clr_val;
    logic              sel_bit;
    logic              cmp_lt;
    logic              cmp_gt;
    logic [ADDR_W-1:0] tgt;

    logic              n_wb_en;
    logic [REG_AW-1:0] n_wb_reg;
    logic [DATA_W-1:0] n_wb_data;
    logic              n_br_taken;
    logic [ADDR_W-1:0] n_br_target;

    // Qualify the raw code with the valid strobe
    always_comb begin
        op = op_valid ? bb_op_e'(op_code) : BB_NOP;
    end

    bitbr_mask_dec #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) mask_i (
        .idx  (bit_idx),
        .mask (mask)
    );

    bitbr_field_op #(
        .DATA_W (DATA_W)
    ) field_i (
        .src     (rs_val),
        .mask    (mask),
        .set_val (set_val),
        .clr_val (clr_val),
        .sel_bit (sel_bit)
    );

    bitbr_cmp #(
        .DATA_W (DATA_W)
    ) cmp_i (
        .a  (rs_val),
        .b  (rt_val),
        .lt (cmp_lt),
        .gt (cmp_gt)
    );

    bitbr_target #(
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .INSN_BYTES (INSN_BYTES)
    ) tgt_i (
        .pc     (pc),
        .offset (br_offset),
        .target (tgt)
    );

    // Choose the next-stage values from the decoded operation
    always_comb begin
        n_wb_en     = 1'b0;
        n_wb_reg    = '0;
        n_wb_data   = '0;
        n_br_taken  = 1'b0;
        n_br_target = '0;
        if (is_bitwrite(op) && (dest_reg != '0)) begin
            n_wb_en   = 1'b1;
            n_wb_reg  = dest_reg;
            n_wb_data = (op == BB_SET) ? set_val : clr_val;
        end
        if (is_branch(op)) begin
            n_br_target = tgt;
            case (op)
                BB_BRSET: n_br_taken = sel_bit;
                BB_BRCLR: n_br_taken = !sel_bit;
                BB_BRLT:  n_br_taken = cmp_lt;
                BB_BRGT:  n_br_taken = cmp_gt;
                default:  n_br_taken = 1'b0;
            endcase
        end
    end

    // Stage boundary register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en     <= 1'b0;
            wb_reg    <= '0;
            wb_data   <= '0;
            br_taken  <= 1'b0;
            br_target <= '0;
        end else begin
            wb_en     <= n_wb_en;
            wb_reg    <= n_wb_reg;
            wb_data   <= n_wb_data;
            br_taken  <= n_br_taken;
            br_target <= n_br_target;
        end
    end

endmodule

// File: rtl/bitbr_unit_chk.sv
// Module bitbr_unit_chk
// Timing properties of bitbr_unit, attached to it with bind. It relates
// the inputs of one cycle to the registered outputs of the next. A
// one-cycle history flag keeps $past off the cycles before reset ends.
module bitbr_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W),
    parameter int REG_AW = 5,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [bitbr_pkg::OP_W-1:0] op_code,
    input logic [DATA_W-1:0]          rs_val,
    input logic [DATA_W-1:0]          rt_val,
    input logic [IDX_W-1:0]           bit_idx,
    input logic [REG_AW-1:0]          dest_reg,
    input logic                       wb_en,
    input logic [REG_AW-1:0]          wb_reg,
    input logic [DATA_W-1:0]          wb_data,
    input logic                       br_taken
);

    logic hist_ok;

    // Mark that the previous cycle was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    assert_wb_br_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && br_taken));

    assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_reg != '0));

    assert_set_bit_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(op_valid && op_code == 3'd1 && dest_reg != '0))
        |-> (wb_en && wb_data[$past(bit_idx)] && wb_reg == $past(dest_reg)));

    assert_clr_bit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(op_valid && op_code == 3'd2 && dest_reg != '0))
        |-> (wb_en && !wb_data[$past(bit_idx)]));

    assert_equal_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(op_valid && (op_code == 3'd5 || op_code == 3'd6)
                          && rs_val == rt_val))
        |-> !br_taken);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(!op_valid)) |-> (!wb_en && !br_taken));

endmodule

bind bitbr_unit bitbr_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .REG_AW (REG_AW),
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .bit_idx  (bit_idx),
    .dest_reg (dest_reg),
    .wb_en    (wb_en),
    .wb_reg   (wb_reg),
    .wb_data  (wb_data),
    .br_taken (br_taken)
);

// File: tb/bitbr_unit_tb_top.sv
// Bench for bitbr_unit: directed corners, then random ops, each compared
// one cycle later with a behavioural model of the requirements.
module bitbr_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [31:0] rs_val, rt_val, pc;
    logic [4:0]  bit_idx, dest_reg;
    logic [15:0] br_offset;
    logic        wb_en, br_taken;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data, br_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bitbr_unit dut_i (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
        .rs_val (rs_val), .rt_val (rt_val), .bit_idx (bit_idx),
        .dest_reg (dest_reg), .pc (pc), .br_offset (br_offset),
        .wb_en (wb_en), .wb_reg (wb_reg), .wb_data (wb_data),
        .br_taken (br_taken), .br_target (br_target)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one op, wait one clock, compare with the model
    task automatic run(input bit v, input int code, input logic [31:0] a,
                       input logic [31:0] b, input int idx, input int dst,
                       input logic [31:0] p, input logic [15:0] off);
        bit          e_wen = 0, e_br = 0;
        logic [31:0] e_data = 0, e_tgt = 0;
        int          e_reg = 0;
        string       tag;
        longint      sa, sb;
        op_valid = v; op_code = 3'(code); rs_val = a; rt_val = b;
        bit_idx = 5'(idx); dest_reg = 5'(dst); pc = p; br_offset = off;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        tag = "R11";
        if (v) begin
            case (code)
                1: begin tag = "R2"; if (dst != 0) begin e_wen = 1; e_reg = dst;
                       e_data = a; e_data[idx] = 1'b1; end else tag = "R10"; end
                2: begin tag = "R3"; if (dst != 0) begin e_wen = 1; e_reg = dst;
                       e_data = a; e_data[idx] = 1'b0; end else tag = "R10"; end
                3: begin tag = "R4"; e_br = (a[idx] == 1'b1); end
                4: begin tag = "R5"; e_br = (a[idx] == 1'b0); end
                5: begin tag = "R6"; e_br = (sa < sb); end
                6: begin tag = "R7"; e_br = (sa > sb); end
                default: tag = "R11";
            endcase
            if (code >= 3 && code <= 6)
                e_tgt = 32'(longint'(p) + 4 + longint'($signed(off)) * 4);
        end
        @(negedge clk);
        chk(tag, "wb_en", wb_en, e_wen);
        chk(tag, "wb_reg", wb_reg, e_reg);
        chk(tag, "wb_data", wb_data, e_data);
        chk((code == 1 || code == 2) ? "R9" : tag, "br_taken", br_taken, e_br);
        chk("R8", "br_target", br_target, e_tgt);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_valid = 1; op_code = 3'd1; rs_val = 32'hFFFF_FFFF;
        rt_val = 0; bit_idx = 5'd3; dest_reg = 5'd7; pc = 32'h100; br_offset = 16'h10;
        @(negedge clk); @(negedge clk);
        // R1 reset state while a write op is presented
        chk("R1", "wb_en", wb_en, 0);
        chk("R1", "wb_reg", wb_reg, 0);
        chk("R1", "wb_data", wb_data, 0);
        chk("R1", "br_taken", br_taken, 0);
        chk("R1", "br_target", br_target, 0);
        rst_n = 1;

        // R2 / R3 at both ends of the word
        run(1, 1, 32'h0000_0000, 0, 0,  5,  32'h0, 16'h0);
        run(1, 1, 32'h1234_5678, 0, 31, 31, 32'h0, 16'h0);
        run(1, 1, 32'hFFFF_FFFF, 0, 9,  2,  32'h0, 16'h0);
        run(1, 2, 32'hFFFF_FFFF, 0, 0,  3,  32'h0, 16'h0);
        run(1, 2, 32'h8000_0001, 0, 31, 4,  32'h0, 16'h0);
        run(1, 2, 32'h0000_0000, 0, 17, 1,  32'h0, 16'h0);
        // R10 destination zero
        run(1, 1, 32'h0, 0, 4, 0, 32'h0, 16'h0);
        run(1, 2, 32'hFFFF_FFFF, 0, 4, 0, 32'h0, 16'h0);
        // R4 / R5 bit branches, positive and negative offsets
        run(1, 3, 32'h8000_0000, 0, 31, 0, 32'h0000_1000, 16'h0003);
        run(1, 3, 32'h7FFF_FFFF, 0, 31, 0, 32'h0000_1000, 16'hFFFF);
        run(1, 4, 32'h0000_0001, 0, 0,  0, 32'h0000_0000, 16'h8000);
        run(1, 4, 32'hFFFF_FFFE, 0, 0,  0, 32'hFFFF_FFFC, 16'h7FFF);
        // R6 / R7 signed extremes and equality
        run(1, 5, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 32'h40, 16'h2);
        run(1, 5, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 32'h40, 16'h2);
        run(1, 5, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 32'h40, 16'h2);
        run(1, 5, 32'h0000_0005, 32'h0000_0005, 0, 0, 32'h40, 16'h2);
        run(1, 6, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 32'h80, 16'hFFFE);
        run(1, 6, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 32'h80, 16'hFFFE);
        run(1, 6, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'h80, 16'hFFFE);
        // R11 idle and unused codes
        run(0, 1, 32'h0, 0, 3, 9, 32'h10, 16'h1);
        run(0, 5, 32'h8000_0000, 32'h1, 3, 9, 32'h10, 16'h1);
        run(1, 0, 32'h0, 0, 3, 9, 32'h10, 16'h1);
        run(1, 7, 32'h1, 32'h2, 3, 9, 32'h10, 16'h1);

        // Mixed random ops, compared each cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = (i % 5 == 0) ? ra : 32'($urandom);
            run(($urandom % 8) != 0, int'($urandom % 8), ra, rb,
                int'($urandom % 32), int'($urandom % 32),
                32'($urandom) & 32'hFFFF_FFFC, 16'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule